// File: doc/BRIEF.md
# Lockable security register controller

This block owns a small security register that lives beside a main byte-addressed memory but has an address space of its own. The low part of the register holds a fixed unique identifier. The identifier is taken from a parameter when reset is applied, and no write can change it. Above the identifier sits a user page that software may program byte by byte. A one-time lock makes that page read-only, and no later command releases it. Only a fresh reset clears the lock.

A host front end, such as a serial-bus decoder, presents one command per clock cycle on a strobe interface. The commands are a byte write, a byte read at an explicit address, a "read next" that continues from the previous read, and the two steps of the lock sequence. Read data comes back one cycle after the strobe together with a valid pulse. A write that the block refuses produces a one-cycle rejection pulse instead.

With the default parameters there are 16 identifier bytes at addresses 0 to 15 and 256 user bytes at addresses 16 to 271. Addresses 272 and above are unmapped.

Top module: `secreg_ctrl`

## Requirements
- R1: A read of address i in 0..15 returns byte i of the identifier parameter, where byte i is bits 8i+7 down to 8i. The data appears on rd_data with rd_valid high in the cycle after the strobe.
- R2: A write to addresses 0..15 leaves the identifier unchanged. It raises write_rejected for exactly the one cycle after the strobe.
- R3: While the block is unlocked, a write to address 16..271 stores the byte, and write_rejected stays low. A later read of that address returns the stored byte.
- R4: A read of an address of 272 or more returns 0xFF. A write to such an address is rejected with a write_rejected pulse.
- R5: A lock_arm command followed by lock_confirm as the next command sets locked_status in the cycle after the confirm. Idle cycles, in which no strobe is high, may separate the two.
- R6: Any other command between lock_arm and lock_confirm cancels the arm. A lock_confirm without a pending arm has no effect.
- R7: Once locked, every write to 16..271 is rejected and leaves the stored byte unchanged. No command clears locked_status; only reset does.
- R8: cmd_read_next reads the address that follows the previous read. After address 271 it wraps to 0. After a read at an unmapped address it continues from 0.
- R9: After reset, rd_valid, write_rejected and locked_status are low. rd_valid pulses only in the cycle after a read command.
- R10: When several strobes are high in one cycle, exactly one command is taken, in this priority: cmd_write, then cmd_read, then cmd_read_next, then lock_arm, then lock_confirm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_addr | input | ADDR_W (9) | Byte address for write and read commands |
| cmd_wdata | input | 8 | Write data |
| cmd_write | input | 1 | Write strobe |
| cmd_read | input | 1 | Read strobe at cmd_addr |
| cmd_read_next | input | 1 | Read strobe at the address after the previous read |
| lock_arm | input | 1 | First step of the lock sequence |
| lock_confirm | input | 1 | Second step of the lock sequence |
| rd_data | output | 8 | Read data, held until the next read |
| rd_valid | output | 1 | One-cycle pulse marking new rd_data |
| write_rejected | output | 1 | One-cycle pulse marking a discarded write |
| locked_status | output | 1 | User page lock bit |

## Verification
The embedded assertions check properties that hold on every cycle:
- the lock never falls once set, and it rises only on a confirm that meets a pending arm;
- an interrupting command always drops the arm;
- the user store is never written while locked;
- identifier writes always produce a rejection;
- unmapped reads always return 0xFF.

Only the bench scenarios can show the rest. These include the actual byte values read back after full sweeps of the identifier, user and unmapped ranges, and the wrap of the read-next pointer at 271. They also cover the distinction between idle cycles and interrupting commands during a lock sequence, and the strobe priority when several strobes are high at once.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RGN_SERIAL = 2'd0,
    RGN_USER   = 2'd1,
    RGN_NONE   = 2'd2
  } region_e;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_READ      = 3'd2,
    OP_READ_NEXT = 3'd3,
    OP_ARM       = 3'd4,
    OP_CONFIRM   = 3'd5
  } op_e;
endpackage

// File: rtl/secreg_addr_map.sv
module secreg_addr_map
  import secreg_pkg::*;
#(
  parameter int SN_BYTES   = 16,
  parameter int USER_BYTES = 256,
  parameter int ADDR_W     = 9,
  localparam int IDX_W     = $clog2(USER_BYTES),
  localparam int SN_IDX_W  = $clog2(SN_BYTES),
  localparam int TOTAL     = SN_BYTES + USER_BYTES
) (
  input  logic [ADDR_W-1:0]   addr,
  output region_e             region,
  output logic [IDX_W-1:0]    user_idx,
  output logic [SN_IDX_W-1:0] sn_idx
);
  always_comb begin
    if (addr < ADDR_W'(SN_BYTES)) begin
      region = RGN_SERIAL;
    end else if (addr < ADDR_W'(TOTAL)) begin
      region = RGN_USER;
    end else begin
      region = RGN_NONE;
    end
    user_idx = IDX_W'(addr - ADDR_W'(SN_BYTES));
    sn_idx   = SN_IDX_W'(addr);
  end
endmodule

// File: rtl/secreg_lock_ctl.sv
module secreg_lock_ctl
  import secreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  op,
  output logic armed,
  output logic locked
);
  logic armed_q, armed_d;
  logic locked_q, locked_d;

  always_comb begin
    armed_d  = armed_q;
    locked_d = locked_q;
    if (op == OP_ARM) begin
      armed_d = 1'b1;
    end else if (op != OP_IDLE) begin
      armed_d = 1'b0;
    end
    if (op == OP_CONFIRM && armed_q) begin
      locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      locked_q <= locked_d;
    end
  end

  assign armed  = armed_q;
  assign locked = locked_q;

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);
  // R5
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(armed_q && op == OP_CONFIRM));
  // R6
  arm_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && op != OP_IDLE && op != OP_ARM) |=> !armed_q);
endmodule

// File: rtl/secreg_user_store.sv
module secreg_user_store
  import secreg_pkg::*;
#(
  parameter int USER_BYTES = 256,
  localparam int IDX_W     = $clog2(USER_BYTES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [USER_BYTES];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/secreg_ctrl.sv
module secreg_ctrl
  import secreg_pkg::*;
#(
  parameter int            SN_BYTES   = 16,
  parameter int            USER_BYTES = 256,
  parameter int            ADDR_W     = 9,
  parameter logic [127:0]  SERIAL_NUM = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0,
  localparam int           IDX_W      = $clog2(USER_BYTES),
  localparam int           SN_IDX_W   = $clog2(SN_BYTES),
  localparam int           TOTAL      = SN_BYTES + USER_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              cmd_write,
  input  logic              cmd_read,
  input  logic              cmd_read_next,
  input  logic              lock_arm,
  input  logic              lock_confirm,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              write_rejected,
  output logic              locked_status
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TOTAL - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // command selection by fixed priority
  op_e op;
  always_comb begin
    if      (cmd_write)     op = OP_WRITE;
    else if (cmd_read)      op = OP_READ;
    else if (cmd_read_next) op = OP_READ_NEXT;
    else if (lock_arm)      op = OP_ARM;
    else if (lock_confirm)  op = OP_CONFIRM;
    else                    op = OP_IDLE;
  end

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] eff_addr;
  assign eff_addr = (op == OP_READ_NEXT) ? ptr_q : cmd_addr;

  region_e             region;
  logic [IDX_W-1:0]    user_idx;
  logic [SN_IDX_W-1:0] sn_idx;

  secreg_addr_map #(
    .SN_BYTES   (SN_BYTES),
    .USER_BYTES (USER_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_map (
    .addr     (eff_addr),
    .region   (region),
    .user_idx (user_idx),
    .sn_idx   (sn_idx)
  );

  logic armed, locked;
  secreg_lock_ctl u_lock (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .op     (op),
    .armed  (armed),
    .locked (locked)
  );

  // identifier bytes, loaded from the parameter at reset
  logic [BYTE_W-1:0] sn_q [SN_BYTES];
  for (genvar g = 0; g < SN_BYTES; g++) begin : g_sn
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) sn_q[g] <= SERIAL_NUM[BYTE_W*g +: BYTE_W];
    end
  end

  logic              user_we;
  logic [BYTE_W-1:0] user_rdata;
  assign user_we = (op == OP_WRITE) && (region == RGN_USER) && !locked;

  secreg_user_store #(.USER_BYTES(USER_BYTES)) u_store (
    .clk   (clk),
    .we    (user_we),
    .idx   (user_idx),
    .wdata (cmd_wdata),
    .rdata (user_rdata)
  );

  // next-state logic
  logic              rd_en, rej_d;
  logic [BYTE_W-1:0] rd_byte;

  always_comb begin
    rd_en = (op == OP_READ) || (op == OP_READ_NEXT);
    rej_d = (op == OP_WRITE) && !user_we;
    case (region)
      RGN_SERIAL: rd_byte = sn_q[sn_idx];
      RGN_USER:   rd_byte = user_rdata;
      default:    rd_byte = 8'hFF;
    endcase
    ptr_d = ptr_q;
    if (rd_en) begin
      ptr_d = (eff_addr >= LAST_ADDR) ? '0 : eff_addr + ADDR_W'(1);
    end
  end

  // registers
  logic [BYTE_W-1:0] rd_data_q;
  logic              rd_valid_q, rej_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      rej_q      <= 1'b0;
      ptr_q      <= '0;
    end else begin
      if (rd_en) rd_data_q <= rd_byte;
      rd_valid_q <= rd_en;
      rej_q      <= rej_d;
      ptr_q      <= ptr_d;
    end
  end

  assign rd_data        = rd_data_q;
  assign rd_valid       = rd_valid_q;
  assign write_rejected = rej_q;
  assign locked_status  = locked;

  // R2
  sn_write_rej_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (op == OP_WRITE && region == RGN_SERIAL) |=> write_rejected);
  // R7
  locked_no_store_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    user_we |-> !locked_status);
  // R3
  open_write_ok_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (op == OP_WRITE && region == RGN_USER && !locked_status) |=> !write_rejected);
  // R4
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_en && region == RGN_NONE) |=> (rd_data == 8'hFF));
  // R9
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_valid |-> $past(cmd_read || cmd_read_next));
  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_en && eff_addr == LAST_ADDR) |=> (ptr_q == '0));
endmodule

// File: tb/tb_secreg_ctrl.sv
`timescale 1ns/1ps
module tb_secreg_ctrl;
  localparam logic [127:0] SN = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic       cmd_write = 0, cmd_read = 0, cmd_read_next = 0;
  logic       lock_arm = 0, lock_confirm = 0;
  logic [7:0] rd_data;
  logic       rd_valid, write_rejected, locked_status;

  int errs = 0;
  int checks = 0;
  logic [7:0] model [256];

  always #2 clk = ~clk;

  secreg_ctrl #(.SERIAL_NUM(SN)) dut (
    .clk, .rst_n, .cmd_addr, .cmd_wdata, .cmd_write, .cmd_read,
    .cmd_read_next, .lock_arm, .lock_confirm,
    .rd_data, .rd_valid, .write_rejected, .locked_status
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic issue(bit w, bit r, bit n, bit a, bit c, int addr, int data);
    @(negedge clk);
    cmd_write = w; cmd_read = r; cmd_read_next = n;
    lock_arm = a; lock_confirm = c;
    cmd_addr = 9'(addr); cmd_wdata = 8'(data);
    @(posedge clk);
    #1;
    cmd_write = 0; cmd_read = 0; cmd_read_next = 0;
    lock_arm = 0; lock_confirm = 0;
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
  endtask

  function automatic int expect_at(int a);
    if (a < 16)  return int'(SN[8*a +: 8]);
    if (a < 272) return int'(model[a-16]);
    return 8'hFF;
  endfunction

  task automatic rd_chk(int a, string tag);
    issue(0, 1, 0, 0, 0, a, 0);
    chk($sformatf("%s valid @%0d", tag, a), rd_valid, 1);
    chk($sformatf("%s data @%0d", tag, a), rd_data, expect_at(a));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) idle();

    // R9 reset state
    chk("R9 rd_valid reset", rd_valid, 0);
    chk("R9 write_rejected reset", write_rejected, 0);
    chk("R9 locked reset", locked_status, 0);

    // R1 identifier sweep
    for (int i = 0; i < 16; i++) rd_chk(i, "R1");

    // R2 identifier writes refused
    for (int i = 0; i < 16; i++) begin
      issue(1, 0, 0, 0, 0, i, 8'h5A);
      chk($sformatf("R2 reject @%0d", i), write_rejected, 1);
      idle();
      chk("R2 pulse one cycle", write_rejected, 0);
    end
    for (int i = 0; i < 16; i++) rd_chk(i, "R2 unchanged");

    // R3 user page write/read sweep
    for (int i = 0; i < 256; i++) begin
      model[i] = 8'((i * 37 + 11) & 255);
      issue(1, 0, 0, 0, 0, i + 16, model[i]);
      chk($sformatf("R3 accept @%0d", i + 16), write_rejected, 0);
    end
    for (int i = 16; i < 272; i++) rd_chk(i, "R3");

    // R4 unmapped range
    for (int i = 272; i < 512; i++) rd_chk(i, "R4");
    issue(1, 0, 0, 0, 0, 272, 1);
    chk("R4 reject 272", write_rejected, 1);
    issue(1, 0, 0, 0, 0, 511, 1);
    chk("R4 reject 511", write_rejected, 1);

    // R8 sequential read with wrap
    rd_chk(268, "R8 start");
    for (int k = 1; k <= 6; k++) begin
      issue(0, 0, 1, 0, 0, 0, 0);
      chk("R8 next valid", rd_valid, 1);
      chk($sformatf("R8 next step %0d", k), rd_data, expect_at((268 + k) % 272));
    end
    rd_chk(300, "R8 unmapped start");
    issue(0, 0, 1, 0, 0, 0, 0);
    chk("R8 after unmapped -> 0", rd_data, expect_at(0));

    // R10 priority: write beats read
    model[4] = 8'hAA;
    issue(1, 1, 0, 0, 0, 20, 8'hAA);
    chk("R10 write wins no valid", rd_valid, 0);
    chk("R10 write wins no reject", write_rejected, 0);
    rd_chk(20, "R10 stored");
    // R10 read beats arm, so the arm is not taken
    issue(0, 1, 0, 1, 0, 5, 0);
    chk("R10 read wins", rd_data, expect_at(5));
    issue(0, 0, 0, 0, 1, 0, 0);
    chk("R10 arm dropped", locked_status, 0);

    // R6 cancel and lone confirm
    issue(0, 0, 0, 1, 0, 0, 0);
    issue(0, 1, 0, 0, 0, 30, 0);
    issue(0, 0, 0, 0, 1, 0, 0);
    chk("R6 interrupted arm", locked_status, 0);
    issue(0, 0, 0, 0, 1, 0, 0);
    chk("R6 lone confirm", locked_status, 0);
    issue(0, 0, 0, 1, 0, 0, 0);
    issue(1, 0, 0, 0, 0, 3, 0);
    issue(0, 0, 0, 0, 1, 0, 0);
    chk("R6 rejected write cancels", locked_status, 0);

    // R5 arm, idles, confirm
    issue(0, 0, 0, 1, 0, 0, 0);
    idle();
    idle();
    chk("R5 not yet locked", locked_status, 0);
    issue(0, 0, 0, 0, 1, 0, 0);
    chk("R5 locked", locked_status, 1);

    // R7 locked page refuses writes
    for (int i = 16; i < 272; i++) begin
      issue(1, 0, 0, 0, 0, i, 8'h00);
      chk($sformatf("R7 reject @%0d", i), write_rejected, 1);
    end
    for (int i = 16; i < 272; i++) rd_chk(i, "R7 unchanged");
    issue(0, 0, 0, 1, 0, 0, 0);
    issue(0, 0, 0, 0, 1, 0, 0);
    issue(0, 1, 0, 0, 0, 0, 0);
    issue(0, 0, 1, 0, 0, 0, 0);
    chk("R7 still locked", locked_status, 1);

    summary();
  end
endmodule